// File: doc/BRIEF.md
# USB Root-Port Ownership Router

This block decides, for each of a set of USB root ports, whether the high-speed host controller or a full/low-speed companion controller serves that port. It holds a global configure flag and one owner bit per port. It drives per-port select lines, and it steers each port's connect and disconnect events to the controller that currently owns the port. Owner bit encoding: 0 means the high-speed controller owns the port, 1 means the companion owns it.

Four reset sources feed the block, and each has its own effect. The standby-domain reset is asynchronous and active low. It is the only reset that clears state across main-power loss. The main-domain reset and the power-state wake leave the ownership state alone, so ports do not have to be enumerated and mapped again after a sleep. The host-controller software reset returns the block to its unconfigured state. When a configured port loses its device, the hardware hands that port back to the high-speed controller.

The design has two enumerated state machines. The flag machine has states `CFG_OFF` and `CFG_ON`. Its transitions are *configure* (write 1 while in `CFG_OFF`), *release* (write 0 while in `CFG_ON`) and *soft reset* (to `CFG_OFF`). Each port machine has states `OWN_HS` and `OWN_COMP`. Its transitions are *claim-all* (the flag rises, go to `OWN_HS`), *hand-back* (a disconnect while configured, go to `OWN_HS`), *software write* (to the state named by the written bit, allowed only while configured) and *soft reset* (to `OWN_COMP`). A reset arbiter reduces the three synchronous reset inputs to one cause, in the priority order soft > main > wake.

Top module: `port_owner_router`

## Requirements
- R1: While `stby_rst_n` is low, and after it is released, `cfg_flag_o` is 0 and every bit of `owner_o` is 1. This happens without a clock edge.
- R2: A cycle with `hc_soft_rst` high makes `cfg_flag_o` 0 and every owner bit 1 at the next clock. It takes priority over configure-flag writes, owner writes and disconnects in the same cycle.
- R3: A cycle with `core_rst` high, and no other write, disconnect or soft reset, leaves `cfg_flag_o` and `owner_o` unchanged.
- R4: A cycle with `wake_rst` high, and no other write, disconnect or soft reset, leaves `cfg_flag_o` and `owner_o` unchanged.
- R5: While `cfg_flag_o` is 1, a `port_disc[i]` pulse makes owner bit i equal 0 at the next clock. This takes priority over an owner write to the same port in the same cycle. While the flag is 0, a disconnect does not change the owner bits.
- R6: In the same cycle, a connect or disconnect pulse on port i appears on `hs_conn_o[i]`/`hs_disc_o[i]` when `hs_sel_o[i]` is 1, and on `comp_conn_o[i]`/`comp_disc_o[i]` otherwise. The companion never sees an event on a port the high-speed controller owns.
- R7: While `cfg_flag_o` is 0, `hs_sel_o` is all 0 and `comp_sel_o` is all 1, whatever the owner bits hold.
- R8: While `cfg_flag_o` is 1, a port with owner bit 0 has `hs_sel_o` set and a port with owner bit 1 has `comp_sel_o` set.
- R9: While the flag is 1, an owner write (`own_wr_en[i]`, value `own_wr_val[i]`) takes effect at the next clock. While the flag is 0 the write is ignored.
- R10: A flag write that changes the flag from 0 to 1 clears every owner bit to 0. A write that changes it from 1 to 0 keeps the owner bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| stby_rst_n | input | 1 | Standby-domain reset, asynchronous, active low |
| core_rst | input | 1 | Main-domain reset pulse (no effect on ownership) |
| wake_rst | input | 1 | Power-state wake reset pulse (no effect on ownership) |
| hc_soft_rst | input | 1 | Host-controller software reset |
| cfg_wr_en | input | 1 | Configure-flag write strobe |
| cfg_wr_val | input | 1 | Configure-flag write value |
| own_wr_en | input | NUM_PORTS | Per-port owner write strobe |
| own_wr_val | input | NUM_PORTS | Per-port owner write value (1 = companion) |
| port_conn | input | NUM_PORTS | Per-port connect event |
| port_disc | input | NUM_PORTS | Per-port disconnect event |
| cfg_flag_o | output | 1 | Configure flag readback |
| owner_o | output | NUM_PORTS | Owner bit readback |
| hs_sel_o | output | NUM_PORTS | Port routed to the high-speed controller |
| comp_sel_o | output | NUM_PORTS | Port routed to the companion controller |
| hs_conn_o | output | NUM_PORTS | Connect event steered to the high-speed controller |
| comp_conn_o | output | NUM_PORTS | Connect event steered to the companion |
| hs_disc_o | output | NUM_PORTS | Disconnect event steered to the high-speed controller |
| comp_disc_o | output | NUM_PORTS | Disconnect event steered to the companion |

## Verification
The assertions treat the input event lines as single-cycle pulses sampled at the clock. The hold checks for the main-domain and wake resets apply only in cycles that carry no write, disconnect or soft reset. The bench drives every stimulus on the falling edge for one cycle and clears it at the next falling edge. It pulses the main-domain and wake resets alone, so the hold checks apply to them. The mixed-priority cases (disconnect against owner write, soft reset against everything) each occupy a single cycle of their own.

// File: rtl/port_owner_pkg.sv
package port_owner_pkg;
    typedef enum logic {
        CFG_OFF = 1'b0,
        CFG_ON  = 1'b1
    } cfg_state_e;

    typedef enum logic {
        OWN_HS   = 1'b0,
        OWN_COMP = 1'b1
    } own_state_e;

    typedef enum logic [1:0] {
        RC_NONE = 2'd0,
        RC_SOFT = 2'd1,
        RC_CORE = 2'd2,
        RC_WAKE = 2'd3
    } rst_cause_e;
endpackage

// File: rtl/porto_rst_arb.sv
module porto_rst_arb
    import port_owner_pkg::*;
(
    input  logic       soft_rst,
    input  logic       core_rst,
    input  logic       wake_rst,
    output rst_cause_e cause_o
);
    // Priority: soft reset, then main domain, then wake.
    always_comb begin
        if (soft_rst)      cause_o = RC_SOFT;
        else if (core_rst) cause_o = RC_CORE;
        else if (wake_rst) cause_o = RC_WAKE;
        else               cause_o = RC_NONE;
    end
endmodule

// File: rtl/porto_cfg_fsm.sv
module porto_cfg_fsm
    import port_owner_pkg::*;
(
    input  logic       clk,
    input  logic       stby_rst_n,
    input  rst_cause_e cause,
    input  logic       wr_en,
    input  logic       wr_val,
    output logic       cfg_on_o,
    output logic       cfg_rise_o
);
    cfg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_OFF: if (wr_en && wr_val)  state_d = CFG_ON;   // configure
            CFG_ON:  if (wr_en && !wr_val) state_d = CFG_OFF;  // release
            default: state_d = CFG_OFF;
        endcase
        if (cause == RC_SOFT) state_d = CFG_OFF;               // soft reset
    end

    always_ff @(posedge clk or negedge stby_rst_n) begin
        if (!stby_rst_n) state_q <= CFG_OFF;
        else             state_q <= state_d;
    end

    always_comb begin
        cfg_on_o   = (state_q == CFG_ON);
        cfg_rise_o = (state_q == CFG_OFF) && (state_d == CFG_ON);
    end

    AST_SOFT_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (cause == RC_SOFT) |=> (state_q == CFG_OFF)) else $error("flag"); // R2
endmodule

// File: rtl/porto_port_fsm.sv
module porto_port_fsm
    import port_owner_pkg::*;
(
    input  logic       clk,
    input  logic       stby_rst_n,
    input  rst_cause_e cause,
    input  logic       cfg_on,
    input  logic       cfg_rise,
    input  logic       conn_evt,
    input  logic       disc_evt,
    input  logic       wr_en,
    input  logic       wr_val,
    output logic       owner_o,
    output logic       hs_sel_o,
    output logic       comp_sel_o,
    output logic       hs_conn_o,
    output logic       comp_conn_o,
    output logic       hs_disc_o,
    output logic       comp_disc_o
);
    own_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cause == RC_SOFT)            state_d = OWN_COMP;  // soft reset
        else if (cfg_rise)               state_d = OWN_HS;    // claim-all
        else if (cfg_on && disc_evt)     state_d = OWN_HS;    // hand-back
        else if (cfg_on && wr_en) begin                       // software write
            unique case (wr_val)
                1'b0:    state_d = OWN_HS;
                1'b1:    state_d = OWN_COMP;
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge stby_rst_n) begin
        if (!stby_rst_n) state_q <= OWN_COMP;
        else             state_q <= state_d;
    end

    always_comb begin
        owner_o     = (state_q == OWN_COMP);
        hs_sel_o    = cfg_on && (state_q == OWN_HS);
        comp_sel_o  = !hs_sel_o;
        hs_conn_o   = conn_evt && hs_sel_o;
        comp_conn_o = conn_evt && !hs_sel_o;
        hs_disc_o   = disc_evt && hs_sel_o;
        comp_disc_o = disc_evt && !hs_sel_o;
    end

    AST_DISC_HANDBACK: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (cause != RC_SOFT && cfg_on && disc_evt) |=> (state_q == OWN_HS)) else $error("disc"); // R5
    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (cause == RC_NONE && !cfg_on && !cfg_rise) |=> $stable(state_q)) else $error("lock"); // R9
    AST_HS_EVT_HIDDEN: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (cfg_on && state_q == OWN_HS) |-> !(comp_conn_o || comp_disc_o)) else $error("steer"); // R6
endmodule

// File: rtl/port_owner_router.sv
module port_owner_router
    import port_owner_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 stby_rst_n,
    input  logic                 core_rst,
    input  logic                 wake_rst,
    input  logic                 hc_soft_rst,
    input  logic                 cfg_wr_en,
    input  logic                 cfg_wr_val,
    input  logic [NUM_PORTS-1:0] own_wr_en,
    input  logic [NUM_PORTS-1:0] own_wr_val,
    input  logic [NUM_PORTS-1:0] port_conn,
    input  logic [NUM_PORTS-1:0] port_disc,
    output logic                 cfg_flag_o,
    output logic [NUM_PORTS-1:0] owner_o,
    output logic [NUM_PORTS-1:0] hs_sel_o,
    output logic [NUM_PORTS-1:0] comp_sel_o,
    output logic [NUM_PORTS-1:0] hs_conn_o,
    output logic [NUM_PORTS-1:0] comp_conn_o,
    output logic [NUM_PORTS-1:0] hs_disc_o,
    output logic [NUM_PORTS-1:0] comp_disc_o
);
    localparam logic [NUM_PORTS-1:0] ALL_COMP = '1;

    rst_cause_e cause;
    logic       cfg_on;
    logic       cfg_rise;

    porto_rst_arb u_arb (
        .soft_rst (hc_soft_rst),
        .core_rst (core_rst),
        .wake_rst (wake_rst),
        .cause_o  (cause)
    );

    porto_cfg_fsm u_cfg (
        .clk        (clk),
        .stby_rst_n (stby_rst_n),
        .cause      (cause),
        .wr_en      (cfg_wr_en),
        .wr_val     (cfg_wr_val),
        .cfg_on_o   (cfg_on),
        .cfg_rise_o (cfg_rise)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        porto_port_fsm u_port (
            .clk         (clk),
            .stby_rst_n  (stby_rst_n),
            .cause       (cause),
            .cfg_on      (cfg_on),
            .cfg_rise    (cfg_rise),
            .conn_evt    (port_conn[p]),
            .disc_evt    (port_disc[p]),
            .wr_en       (own_wr_en[p]),
            .wr_val      (own_wr_val[p]),
            .owner_o     (owner_o[p]),
            .hs_sel_o    (hs_sel_o[p]),
            .comp_sel_o  (comp_sel_o[p]),
            .hs_conn_o   (hs_conn_o[p]),
            .comp_conn_o (comp_conn_o[p]),
            .hs_disc_o   (hs_disc_o[p]),
            .comp_disc_o (comp_disc_o[p])
        );
    end

    assign cfg_flag_o = cfg_on;

    AST_SOFT_RESET_STATE: assert property (@(posedge clk) disable iff (!stby_rst_n)
        hc_soft_rst |=> (!cfg_flag_o && owner_o == ALL_COMP)) else $error("soft"); // R2
    AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (core_rst && !hc_soft_rst && !cfg_wr_en && own_wr_en == '0 && port_disc == '0)
        |=> ($stable(cfg_flag_o) && $stable(owner_o))) else $error("core"); // R3
    AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!stby_rst_n)
        (wake_rst && !hc_soft_rst && !cfg_wr_en && own_wr_en == '0 && port_disc == '0)
        |=> ($stable(cfg_flag_o) && $stable(owner_o))) else $error("wake"); // R4
    AST_CLAIM_ALL: assert property (@(posedge clk) disable iff (!stby_rst_n)
        $rose(cfg_flag_o) |-> (owner_o == '0)) else $error("claim"); // R10
    AST_UNCFG_ROUTE: assert property (@(posedge clk) disable iff (!stby_rst_n)
        !cfg_flag_o |-> (hs_conn_o == '0 && hs_disc_o == '0)) else $error("route"); // R7
endmodule

// File: tb/tb_port_owner_router.sv
module tb_port_owner_router;
    localparam int N = 4;

    logic clk = 1'b0;
    logic stby_rst_n = 1'b0;
    logic core_rst = 1'b0, wake_rst = 1'b0, hc_soft_rst = 1'b0;
    logic cfg_wr_en = 1'b0, cfg_wr_val = 1'b0;
    logic [N-1:0] own_wr_en = '0, own_wr_val = '0, port_conn = '0, port_disc = '0;
    logic cfg_flag_o;
    logic [N-1:0] owner_o, hs_sel_o, comp_sel_o, hs_conn_o, comp_conn_o, hs_disc_o, comp_disc_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    port_owner_router #(.NUM_PORTS(N)) dut (
        .clk(clk), .stby_rst_n(stby_rst_n), .core_rst(core_rst), .wake_rst(wake_rst),
        .hc_soft_rst(hc_soft_rst), .cfg_wr_en(cfg_wr_en), .cfg_wr_val(cfg_wr_val),
        .own_wr_en(own_wr_en), .own_wr_val(own_wr_val), .port_conn(port_conn),
        .port_disc(port_disc), .cfg_flag_o(cfg_flag_o), .owner_o(owner_o),
        .hs_sel_o(hs_sel_o), .comp_sel_o(comp_sel_o), .hs_conn_o(hs_conn_o),
        .comp_conn_o(comp_conn_o), .hs_disc_o(hs_disc_o), .comp_disc_o(comp_disc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        core_rst = 0; wake_rst = 0; hc_soft_rst = 0; cfg_wr_en = 0; cfg_wr_val = 0;
        own_wr_en = '0; own_wr_val = '0; port_conn = '0; port_disc = '0;
    endtask

    // Stimulus already applied after a falling edge: let one rising edge pass, then settle.
    task automatic step();
        @(posedge clk); #1;
        @(negedge clk); clear_inputs();
    endtask

    task automatic write_cfg(input logic v);
        @(negedge clk); cfg_wr_en = 1; cfg_wr_val = v; step();
    endtask

    task automatic write_owner(input logic [N-1:0] en, input logic [N-1:0] val);
        @(negedge clk); own_wr_en = en; own_wr_val = val; step();
    endtask

    task automatic t_standby_reset();
        @(negedge clk); stby_rst_n = 0; #3;
        chk("R1 flag in reset", {31'd0, cfg_flag_o}, 0);
        chk("R1 owners in reset", {28'd0, owner_o}, 32'hF);
        @(negedge clk); stby_rst_n = 1; #1;
        chk("R1 owners after release", {28'd0, owner_o}, 32'hF);
        chk("R7 hs_sel unconfigured", {28'd0, hs_sel_o}, 0);
        chk("R7 comp_sel unconfigured", {28'd0, comp_sel_o}, 32'hF);
    endtask

    task automatic t_locked();
        write_owner(4'hF, 4'h0);
        chk("R9 write ignored while unconfigured", {28'd0, owner_o}, 32'hF);
        @(negedge clk); port_disc = 4'h3; #1;
        chk("R6 disc to companion when unconfigured", {28'd0, comp_disc_o}, 32'h3);
        step();
        chk("R5 disconnect ignored while unconfigured", {28'd0, owner_o}, 32'hF);
    endtask

    task automatic t_cfg_rise();
        write_cfg(1);
        chk("R10 flag set", {31'd0, cfg_flag_o}, 1);
        chk("R10 claim-all owners", {28'd0, owner_o}, 0);
        chk("R8 all high-speed", {28'd0, hs_sel_o}, 32'hF);
    endtask

    task automatic t_owner_write();
        write_owner(4'hA, 4'hA);
        chk("R9 owner write applied", {28'd0, owner_o}, 32'hA);
        chk("R8 hs_sel mix", {28'd0, hs_sel_o}, 32'h5);
        chk("R8 comp_sel mix", {28'd0, comp_sel_o}, 32'hA);
    endtask

    task automatic t_steer();
        @(negedge clk); port_conn = 4'hF; #1;
        chk("R6 hs connect steering", {28'd0, hs_conn_o}, 32'h5);
        chk("R6 comp connect steering", {28'd0, comp_conn_o}, 32'hA);
        @(negedge clk); port_conn = '0; port_disc = 4'h1; #1;
        chk("R6 hs-owned disc stays hs", {28'd0, hs_disc_o}, 32'h1);
        chk("R6 companion sees no disc", {28'd0, comp_disc_o}, 0);
        step();
    endtask

    task automatic t_disconnect();
        @(negedge clk);
        port_disc = 4'h8; own_wr_en = 4'hC; own_wr_val = 4'hC;
        step();
        chk("R5 disconnect beats write", {28'd0, owner_o}, 32'h6);
    endtask

    task automatic t_core_wake();
        @(negedge clk); core_rst = 1; step();
        chk("R3 core reset owners", {28'd0, owner_o}, 32'h6);
        chk("R3 core reset flag", {31'd0, cfg_flag_o}, 1);
        @(negedge clk); wake_rst = 1; step();
        chk("R4 wake owners", {28'd0, owner_o}, 32'h6);
        chk("R4 wake flag", {31'd0, cfg_flag_o}, 1);
    endtask

    task automatic t_cfg_fall();
        write_cfg(0);
        chk("R10 flag cleared", {31'd0, cfg_flag_o}, 0);
        chk("R10 owners kept on release", {28'd0, owner_o}, 32'h6);
        chk("R7 no hs after release", {28'd0, hs_sel_o}, 0);
    endtask

    task automatic t_soft_reset();
        write_cfg(1);
        write_owner(4'hF, 4'h5);
        chk("R9 second write", {28'd0, owner_o}, 32'h5);
        @(negedge clk);
        hc_soft_rst = 1; port_disc = 4'h2; cfg_wr_en = 1; cfg_wr_val = 1;
        own_wr_en = 4'hF; own_wr_val = 4'h0;
        step();
        chk("R2 soft reset flag", {31'd0, cfg_flag_o}, 0);
        chk("R2 soft reset owners", {28'd0, owner_o}, 32'hF);
    endtask

    task automatic t_standby_again();
        write_cfg(1);
        chk("R10 claim again", {28'd0, owner_o}, 0);
        t_standby_reset();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (2) @(posedge clk);
        t_standby_reset();
        t_locked();
        t_cfg_rise();
        t_owner_write();
        t_steer();
        t_disconnect();
        t_core_wake();
        t_cfg_fall();
        t_soft_reset();
        t_standby_again();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule